// File: doc/BRIEF.md
# Reduced-Pin Ethernet Transmit Encoder

This block sits between a byte-wide Ethernet MAC transmitter and a pair of double-data-rate output cells. Each cycle of the transmit clock it produces two values for the 4-bit data bus and two values for the single control line. One value is for the rising edge and one is for the falling edge. The output cells put these values on the pins. The block does not generate the transmit clock or build the I/O cells. It runs from the transmit clock, which is 125 MHz, 25 MHz or 2.5 MHz depending on the selected line rate.

At gigabit rate one byte leaves per clock. The low nibble goes on the rising edge and the high nibble on the falling edge. At 10 and 100 Mb/s the data is single-rate. Each byte takes two clocks, low nibble first. The falling-edge value copies the rising-edge value, so a DDR cell acts as a plain register. A byte-ready strobe tells the MAC when the presented byte is taken. The control line carries the enable on the rising edge and enable XOR error on the falling edge. A new rate selection is adopted only between frames.

Top module: `rgmii_tx_enc`

## Requirements
- R1: After reset the data outputs are 0, both control outputs are 0, `byte_rdy` is 1 and the rate is 10 Mb/s.
- R2: `ctl_rise` equals the `mac_en` value of the byte being sent, starting one clock after that byte is accepted.
- R3: `ctl_fall` equals `mac_en` XOR `mac_err` of the byte being sent, starting one clock after that byte is accepted.
- R4: At gigabit rate `byte_rdy` is 1 every cycle. One clock after acceptance, `txd_rise` is byte bits 3:0 and `txd_fall` is byte bits 7:4.
- R5: At 10/100 a byte takes two clocks. In the first clock after acceptance both data outputs carry bits 3:0. In the second clock both carry bits 7:4.
- R6: At 10/100, `byte_rdy` is 1 only when a new byte can be taken, and is 0 in the cycle after an active byte is accepted. Inputs presented while `byte_rdy` is 0 have no effect on any output.
- R7: A byte accepted with `mac_en` and `mac_err` both 0 drives both data outputs and both control outputs to 0.
- R8: The `speed_sel` encoding is 00 for 10 Mb/s, 01 for 100 Mb/s, and 10 or 11 for 1000 Mb/s. The selection is adopted only at an edge where `byte_rdy` is 1 and `mac_en` and `mac_err` are both 0. At any other edge it is ignored.
- R9: A byte accepted with `mac_en` 0 and `mac_err` 1 is still sent on the data outputs, with `ctl_rise` 0 and `ctl_fall` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 2 | Requested line rate |
| mac_data | input | 8 | Byte from the MAC |
| mac_en | input | 1 | Transmit enable from the MAC |
| mac_err | input | 1 | Transmit error from the MAC |
| byte_rdy | output | 1 | The presented byte is taken at the next edge |
| txd_rise | output | 4 | Data nibble for the rising edge |
| txd_fall | output | 4 | Data nibble for the falling edge |
| ctl_rise | output | 1 | Control value for the rising edge |
| ctl_fall | output | 1 | Control value for the falling edge |

## Verification
Every output is registered. A byte accepted at one edge shows its first nibble pair and its control pair after that edge. At 10/100 its second nibble pair follows one edge later. `byte_rdy` is combinational from registered state and is valid before the accepting edge. The bench drives inputs on the falling clock edge and reads outputs on the next falling edge. Each check therefore sees exactly the results of the single rising edge in between. Rate changes are checked by counting edges: the first edge where the adoption condition holds takes the new rate, and the byte after it must use the new rate.

// File: rtl/rgmii_tx_pkg.sv
package rgmii_tx_pkg;

  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10
  } spd_e;

  // Map the raw select to a rate; the spare code selects gigabit.
  function automatic spd_e decode_spd(input logic [1:0] sel);
    spd_e r;
    case (sel)
      2'b00:   r = SPD_10;
      2'b01:   r = SPD_100;
      default: r = SPD_1000;
    endcase
    return r;
  endfunction

  // Both clock edges carry data only at gigabit rate.
  function automatic logic spd_is_dual(input spd_e s);
    return (s == SPD_1000);
  endfunction

endpackage

// File: rtl/tx_speed_ctrl.sv
module tx_speed_ctrl
  import rgmii_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  input  logic       accept_i,
  input  logic       active_i,
  output logic       dual_o
);

  spd_e spd_q;
  spd_e spd_d;
  logic spd_ce;

  // Rate may only change on a byte boundary with no activity.
  always_comb begin
    spd_ce = accept_i && !active_i;
    spd_d  = decode_spd(sel_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spd_q <= SPD_10;
    end else if (spd_ce) begin
      spd_q <= spd_d;
    end
  end

  assign dual_o = spd_is_dual(spd_q);

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_i || active_i) |=> $stable(spd_q));

endmodule

// File: rtl/tx_nibble_seq.sv
module tx_nibble_seq #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dual_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              active_i,
  output logic              rdy_o,
  output logic [DATA_W/2-1:0] rise_o,
  output logic [DATA_W/2-1:0] fall_o
);

  localparam int NIB_W = DATA_W / 2;

  logic             second_q, second_d;
  logic [NIB_W-1:0] hold_q, hold_d;
  logic [NIB_W-1:0] rise_q, rise_d;
  logic [NIB_W-1:0] fall_q, fall_d;
  logic [NIB_W-1:0] lo_nib, hi_nib;

  // Split the incoming byte; zero it when the lane is idle.
  always_comb begin
    for (int i = 0; i < NIB_W; i++) begin
      lo_nib[i] = data_i[i]         & active_i;
      hi_nib[i] = data_i[i + NIB_W] & active_i;
    end
  end

  assign rdy_o = !second_q;

  always_comb begin
    second_d = second_q;
    hold_d   = hold_q;
    rise_d   = rise_q;
    fall_d   = fall_q;
    if (dual_i) begin
      second_d = 1'b0;
      rise_d   = lo_nib;
      fall_d   = hi_nib;
    end else if (!second_q) begin
      second_d = active_i;
      hold_d   = hi_nib;
      rise_d   = lo_nib;
      fall_d   = lo_nib;
    end else begin
      second_d = 1'b0;
      rise_d   = hold_q;
      fall_d   = hold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q <= 1'b0;
      hold_q   <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
    end else begin
      second_q <= second_d;
      hold_q   <= hold_d;
      rise_q   <= rise_d;
      fall_q   <= fall_d;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;

  p_rdy_dual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dual_i |-> rdy_o);

  p_rdy_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_o |=> rdy_o);

  p_single_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_i |-> (rise_o == fall_o));

endmodule

// File: rtl/tx_ctl_enc.sv
module tx_ctl_enc (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic en_i,
  input  logic err_i,
  output logic ctl_rise_o,
  output logic ctl_fall_o
);

  logic en_q, en_d;
  logic xr_q, xr_d;

  // Capture only at acceptance; hold across the second nibble.
  always_comb begin
    en_d = en_q;
    xr_d = xr_q;
    if (load_i) begin
      en_d = en_i;
      xr_d = en_i ^ err_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      xr_q <= 1'b0;
    end else begin
      en_q <= en_d;
      xr_q <= xr_d;
    end
  end

  assign ctl_rise_o = en_q;
  assign ctl_fall_o = xr_q;

  p_ctl_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ctl_rise_o == $past(en_i)));

  p_ctl_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ctl_fall_o == ($past(en_i) ^ $past(err_i))));

  p_ctl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(ctl_rise_o) && $stable(ctl_fall_o)));

endmodule

// File: rtl/rgmii_tx_enc.sv
module rgmii_tx_enc #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        speed_sel,
  input  logic [DATA_W-1:0] mac_data,
  input  logic              mac_en,
  input  logic              mac_err,
  output logic              byte_rdy,
  output logic [DATA_W/2-1:0] txd_rise,
  output logic [DATA_W/2-1:0] txd_fall,
  output logic              ctl_rise,
  output logic              ctl_fall
);

  logic dual;
  logic active;
  logic rdy;

  assign active   = mac_en | mac_err;
  assign byte_rdy = rdy;

  tx_speed_ctrl u_speed (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (speed_sel),
    .accept_i (rdy),
    .active_i (active),
    .dual_o   (dual)
  );

  tx_nibble_seq #(.DATA_W(DATA_W)) u_nib (
    .clk      (clk),
    .rst_n    (rst_n),
    .dual_i   (dual),
    .data_i   (mac_data),
    .active_i (active),
    .rdy_o    (rdy),
    .rise_o   (txd_rise),
    .fall_o   (txd_fall)
  );

  tx_ctl_enc u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (rdy),
    .en_i       (mac_en),
    .err_i      (mac_err),
    .ctl_rise_o (ctl_rise),
    .ctl_fall_o (ctl_fall)
  );

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !active) |=> (txd_rise == '0 && txd_fall == '0 && !ctl_rise && !ctl_fall));

  p_gig_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dual && active) |=> (txd_rise == $past(mac_data[DATA_W/2-1:0]) &&
                          txd_fall == $past(mac_data[DATA_W-1:DATA_W/2])));

endmodule

// File: tb/tb_rgmii_tx_enc.sv
module tb_rgmii_tx_enc;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] speed_sel;
  logic [7:0] mac_data;
  logic       mac_en, mac_err;
  logic       byte_rdy;
  logic [3:0] txd_rise, txd_fall;
  logic       ctl_rise, ctl_fall;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rgmii_tx_enc dut (
    .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .mac_data(mac_data),
    .mac_en(mac_en), .mac_err(mac_err), .byte_rdy(byte_rdy),
    .txd_rise(txd_rise), .txd_fall(txd_fall),
    .ctl_rise(ctl_rise), .ctl_fall(ctl_fall)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] sp, input logic [7:0] d, input logic en, input logic er);
    speed_sel = sp; mac_data = d; mac_en = en; mac_err = er;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Output bundle: {rise, fall, ctl_rise, ctl_fall}
  function automatic int outs();
    return {txd_rise, txd_fall, ctl_rise, ctl_fall};
  endfunction

  task automatic t_reset();
    chk("R1 outputs", outs(), 0);
    chk("R1 byte_rdy", byte_rdy, 1);
    // Reset rate is 10 Mb/s: an active byte takes two clocks
    drive(2'b00, 8'h81, 1'b1, 1'b0);
    tick();
    chk("R1 slow after reset", byte_rdy, 0);
    chk("R1 first nibble", outs(), {4'h1, 4'h1, 1'b1, 1'b1});
    drive(2'b00, 8'h00, 1'b0, 1'b0);
    tick();
    chk("R1 second nibble", outs(), {4'h8, 4'h8, 1'b1, 1'b1});
    tick();
  endtask

  task automatic t_gig_frame();
    logic [7:0] bytes [3] = '{8'hA5, 8'h3C, 8'hF0};
    drive(2'b10, 8'h00, 1'b0, 1'b0);
    tick();
    foreach (bytes[i]) begin
      drive(2'b10, bytes[i], 1'b1, 1'b0);
      chk("R4 rdy each cycle", byte_rdy, 1);
      tick();
      chk("R4 R2 R3 gig byte", outs(), {bytes[i][3:0], bytes[i][7:4], 1'b1, 1'b1});
    end
    drive(2'b10, 8'hFF, 1'b0, 1'b0);
    tick();
    chk("R7 idle after frame", outs(), 0);
  endtask

  task automatic t_gig_err();
    drive(2'b11, 8'h7E, 1'b1, 1'b1);
    tick();
    chk("R3 error in frame", outs(), {4'hE, 4'h7, 1'b1, 1'b0});
    drive(2'b11, 8'hC3, 1'b0, 1'b1);
    tick();
    chk("R9 error without enable", outs(), {4'h3, 4'hC, 1'b0, 1'b1});
    drive(2'b11, 8'h00, 1'b0, 1'b0);
    tick();
  endtask

  task automatic t_switch_locked();
    drive(2'b00, 8'h21, 1'b1, 1'b0);
    tick();
    chk("R8 rate held in frame", outs(), {4'h1, 4'h2, 1'b1, 1'b1});
    chk("R8 rdy still gig", byte_rdy, 1);
    drive(2'b00, 8'h43, 1'b1, 1'b0);
    tick();
    chk("R8 second byte gig", outs(), {4'h3, 4'h4, 1'b1, 1'b1});
    drive(2'b01, 8'h00, 1'b0, 1'b0);
    tick();
    drive(2'b01, 8'h65, 1'b1, 1'b0);
    tick();
    chk("R8 adopted slow", outs(), {4'h5, 4'h5, 1'b1, 1'b1});
    chk("R8 slow rdy low", byte_rdy, 0);
    drive(2'b01, 8'h00, 1'b0, 1'b0);
    tick();
    tick();
  endtask

  task automatic t_slow_frame();
    logic [7:0] bytes [2] = '{8'h5A, 8'h96};
    foreach (bytes[i]) begin
      drive(2'b01, bytes[i], 1'b1, 1'b0);
      chk("R6 rdy before byte", byte_rdy, 1);
      tick();
      chk("R5 low nibble both edges", outs(), {bytes[i][3:0], bytes[i][3:0], 1'b1, 1'b1});
      chk("R6 rdy low", byte_rdy, 0);
      drive(2'b10, 8'hFF, 1'b0, 1'b1);
      tick();
      chk("R5 R6 high nibble, ignored inputs", outs(), {bytes[i][7:4], bytes[i][7:4], 1'b1, 1'b1});
      chk("R6 rdy back", byte_rdy, 1);
    end
    drive(2'b01, 8'hFF, 1'b0, 1'b0);
    tick();
    chk("R7 slow idle", outs(), 0);
    drive(2'b01, 8'h3C, 1'b1, 1'b1);
    tick();
    chk("R3 slow error first", outs(), {4'hC, 4'hC, 1'b1, 1'b0});
    drive(2'b01, 8'h00, 1'b0, 1'b0);
    tick();
    chk("R3 slow error second", outs(), {4'h3, 4'h3, 1'b1, 1'b0});
  endtask

  task automatic t_slow_to_gig();
    drive(2'b01, 8'hB7, 1'b1, 1'b0);
    tick();
    drive(2'b10, 8'h00, 1'b0, 1'b0);
    tick();
    chk("R8 not adopted mid-byte", outs(), {4'hB, 4'hB, 1'b1, 1'b1});
    tick();
    chk("R7 idle boundary", outs(), 0);
    drive(2'b10, 8'hD2, 1'b1, 1'b0);
    chk("R8 gig rdy", byte_rdy, 1);
    tick();
    chk("R8 R4 adopted gig", outs(), {4'h2, 4'hD, 1'b1, 1'b1});
    chk("R4 rdy high", byte_rdy, 1);
    drive(2'b10, 8'hFF, 1'b0, 1'b0);
    tick();
    chk("R7 gig idle data masked", outs(), 0);
  endtask

  initial begin
    fork
      begin
        rst_n = 1'b0;
        drive(2'b00, 8'h00, 1'b0, 1'b0);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_gig_frame();
        t_gig_err();
        t_switch_locked();
        t_slow_frame();
        t_slow_to_gig();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule